// File: doc/BRIEF.md
# Three-Mode 16-bit Down Timer with Dual Capture

This block is a 16-bit down-counter with two 16-bit companion registers, A and B. A 3-bit mode field picks one of three jobs. In waveform mode the counter runs from a clock-enable tick and reloads in turn from A and from B, so A and B set the widths of the two output levels. In event mode it counts edges on an external pin. In capture mode it decrements on every tick and copies its value into A or B when the matching pin shows an edge.

Software reaches the control word, the counter and both companion registers through a byte-wide register port. Reads return data on the same cycle. Each of the two interrupt request lines is the AND of a sticky pending flag and its enable. One control bit changes meaning with the mode. In the counting modes it starts and stops the counter. In capture mode it becomes a sticky underflow flag.

Top module: `dual_reg_timer`

## Requirements
- R1: After reset the control word, the counter, A, B and the edge-select register all read 0, and `pwm_out`, `irq_a` and `irq_b` are 0.
- R2: Register addresses are as follows. 0 is the control word. 1 and 2 are the counter low and high bytes. 3 and 4 are A low and high. 5 and 6 are B low and high. 7 is edge select. Bytes of A and B written while no capture happens read back unchanged.
- R3: Control bits [7:5] hold the mode. 3'b100 selects waveform mode, 3'b000 event mode and 3'b110 capture mode. Any other code holds the counter at its value.
- R4: Waveform mode runs while control bit 4 is 1. It decrements on each tick. A tick at count 0 reloads the counter instead. The reload comes from A when `pwm_out` is 0, which drives `pwm_out` to 1 and sets pending A. The reload comes from B when `pwm_out` is 1, which drives `pwm_out` to 0. With a tick every cycle, a level reloaded from value V lasts V+1 cycles.
- R5: Event mode runs while control bit 4 is 1. Each selected edge on `pin_a` decrements the counter. An edge at count 0 reloads the counter from A and sets pending A. With bit 4 at 0, edges leave the counter alone.
- R6: In capture mode a selected edge on `pin_a` copies the counter into A and sets pending A (control bit 3). A selected edge on `pin_b` copies it into B and sets pending B (control bit 1).
- R7: In capture mode the counter decrements on every tick. It wraps from 0x0000 to 0xFFFF, and that wrap sets control bit 4 as an underflow flag.
- R8: Hardware sets a pending flag. Only a control write with a 0 in that bit clears it. A 1 written to it leaves it unchanged. A set in the same cycle as a clear wins.
- R9: `irq_a` is high while enable A (bit 2) is 1 and either pending A is set or the mode is capture with bit 4 set. `irq_b` is high while enable B (bit 0) and pending B are both 1.
- R10: Both pins pass through a two-flop synchronizer. Edge-select bit 0 (pin A) and bit 1 (pin B) pick the edge: 0 for rising, 1 for falling. An edge of the other direction is ignored. A pin change takes effect on the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pin_a | input | 1 | External input A (event count / capture A) |
| pin_b | input | 1 | External input B (capture B) |
| pwm_out | output | 1 | Waveform output |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
The waveform mode is driven with random pairs of A and B reload values. Measuring the high and low run lengths on the pin separates the A and B reload paths and exposes off-by-one errors at the zero count. Capture is tried with random spacings between the A and B pin edges. Comparing the difference of the captured values with the spacing shows whether both channels sample the same running count. Event counting uses random preset counts and pulse totals, some below and some past the reload. Directed cases cover falling-edge selection, the capture-mode wrap flag and its clearing, idle mode codes, and writes of 1 to pending flags.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam logic [2:0] MODE_EVT = 3'b000;
  localparam logic [2:0] MODE_PWM = 3'b100;
  localparam logic [2:0] MODE_CAP = 3'b110;

  // control word bit positions
  localparam int CB_EB   = 0;
  localparam int CB_PB   = 1;
  localparam int CB_EA   = 2;
  localparam int CB_PA   = 3;
  localparam int CB_RUN  = 4;
  localparam int CB_MODE = 5;

  typedef struct packed {
    logic reload_a;  // waveform reload from A
    logic reload_b;  // waveform reload from B
    logic evt_uf;    // event-mode underflow
    logic cap_uf;    // capture-mode wrap
    logic cap_a;     // capture into A
    logic cap_b;     // capture into B
  } tmr_events_t;
endpackage

// File: rtl/dtmr_edge_sync.sv
module dtmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              rise_w;
  logic              fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_w   = sync_q[STAGES-1] & ~last_q;
  assign fall_w   = ~sync_q[STAGES-1] & last_q;
  assign edge_hit = fall_sel ? fall_w : rise_w;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> !rise_w); // R10
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> !fall_w); // R10
endmodule

// File: rtl/dtmr_count_core.sv
module dtmr_count_core
  import dtmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode,
  input  logic                 run,
  input  logic                 tick,
  input  logic                 edge_a,
  input  logic                 edge_b,
  input  logic [W/BW-1:0]      wr_cnt,
  input  logic [W/BW-1:0]      wr_a,
  input  logic [W/BW-1:0]      wr_b,
  input  logic [BW-1:0]        wdata,
  output logic [W-1:0]         cnt,
  output logic [W-1:0]         reg_a,
  output logic [W-1:0]         reg_b,
  output logic                 pwm,
  output tmr_events_t          ev
);
  localparam int NB = W / BW;

  function automatic logic [W-1:0] count_down(input logic [W-1:0] v);
    return v - {{(W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [W-1:0] merge_bytes(input logic [W-1:0] old,
                                               input logic [NB-1:0] sel,
                                               input logic [BW-1:0] d);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < NB; i++)
      if (sel[i]) r[i*BW +: BW] = d;
    return r;
  endfunction

  logic [W-1:0] cnt_q, cnt_d, ra_q, ra_d, rb_q, rb_d;
  logic         pwm_q, pwm_d;
  logic         is_pwm, is_evt, is_cap, is_idle;
  logic         cnt_wr, at_zero;
  logic         step_pwm, step_evt, step_cap;

  assign is_pwm  = (mode == MODE_PWM);
  assign is_evt  = (mode == MODE_EVT);
  assign is_cap  = (mode == MODE_CAP);
  assign is_idle = !(is_pwm || is_evt || is_cap);
  assign cnt_wr  = |wr_cnt;
  assign at_zero = (cnt_q == '0);

  assign step_pwm = is_pwm & run & tick & !cnt_wr;
  assign step_evt = is_evt & run & edge_a & !cnt_wr;
  assign step_cap = is_cap & tick & !cnt_wr;

  assign ev.reload_a = step_pwm & at_zero & !pwm_q;
  assign ev.reload_b = step_pwm & at_zero & pwm_q;
  assign ev.evt_uf   = step_evt & at_zero;
  assign ev.cap_uf   = step_cap & at_zero;
  assign ev.cap_a    = is_cap & edge_a;
  assign ev.cap_b    = is_cap & edge_b;

  always_comb begin
    cnt_d = cnt_q;
    pwm_d = pwm_q;
    if (cnt_wr) begin
      cnt_d = merge_bytes(cnt_q, wr_cnt, wdata);
    end else if (ev.reload_a || ev.evt_uf) begin
      cnt_d = ra_q;
    end else if (ev.reload_b) begin
      cnt_d = rb_q;
    end else if (step_pwm || step_evt || step_cap) begin
      cnt_d = count_down(cnt_q);
    end
    if (ev.reload_a) pwm_d = 1'b1;
    if (ev.reload_b) pwm_d = 1'b0;
  end

  always_comb begin
    ra_d = ev.cap_a ? cnt_q : merge_bytes(ra_q, wr_a, wdata);
    rb_d = ev.cap_b ? cnt_q : merge_bytes(rb_q, wr_b, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ra_q  <= ra_d;
      rb_q  <= rb_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt   = cnt_q;
  assign reg_a = ra_q;
  assign reg_b = rb_q;
  assign pwm   = pwm_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && !cnt_wr) |=> (cnt_q == $past(cnt_q))); // R3
  AST_PWM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.reload_a || ev.reload_b) |=> (pwm_q != $past(pwm_q))); // R4
  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cap_a |=> (ra_q == $past(cnt_q))); // R6
  AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cap_b |=> (rb_q == $past(cnt_q))); // R6
  AST_CAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cap_uf |=> (cnt_q == '1)); // R7
  AST_EVT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev.evt_uf |=> (cnt_q == $past(ra_q))); // R5
endmodule

// File: rtl/dtmr_ctrl_regs.sv
module dtmr_ctrl_regs
  import dtmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_pol,
  input  logic [7:0]  wdata,
  input  tmr_events_t ev,
  output logic [7:0]  ctrl,
  output logic [1:0]  pol,
  output logic [2:0]  mode,
  output logic        run,
  output logic        irq_a,
  output logic        irq_b
);
  logic [7:0] ctrl_q, ctrl_d;
  logic [1:0] pol_q;
  logic       set_a, cap_now, cap_next;
  logic       clr_a, clr_b;

  assign set_a    = ev.reload_a | ev.evt_uf | ev.cap_a;
  assign cap_now  = (ctrl_q[CB_MODE +: 3] == MODE_CAP);
  assign cap_next = (wdata[CB_MODE +: 3] == MODE_CAP);
  assign clr_a    = wr_ctrl & !wdata[CB_PA];
  assign clr_b    = wr_ctrl & !wdata[CB_PB];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d[CB_MODE +: 3] = wdata[CB_MODE +: 3];
      ctrl_d[CB_EA]        = wdata[CB_EA];
      ctrl_d[CB_EB]        = wdata[CB_EB];
      ctrl_d[CB_RUN]       = cap_next ? ((ctrl_q[CB_RUN] & wdata[CB_RUN] & cap_now) | ev.cap_uf)
                                      : wdata[CB_RUN];
    end else begin
      ctrl_d[CB_RUN] = ctrl_q[CB_RUN] | ev.cap_uf;
    end
    ctrl_d[CB_PA] = set_a    | (ctrl_q[CB_PA] & !clr_a);
    ctrl_d[CB_PB] = ev.cap_b | (ctrl_q[CB_PB] & !clr_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pol_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_pol) pol_q <= wdata[1:0];
    end
  end

  assign ctrl  = ctrl_q;
  assign pol   = pol_q;
  assign mode  = ctrl_q[CB_MODE +: 3];
  assign run   = ctrl_q[CB_RUN];
  assign irq_a = ctrl_q[CB_EA] & (ctrl_q[CB_PA] | (cap_now & ctrl_q[CB_RUN]));
  assign irq_b = ctrl_q[CB_EB] & ctrl_q[CB_PB];

  AST_PEND_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[CB_PA]) |-> $past(wr_ctrl && !wdata[CB_PA])); // R8
  AST_PEND_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[CB_PB]) |-> $past(wr_ctrl && !wdata[CB_PB])); // R8
  AST_PEND_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_a |=> ctrl_q[CB_PA]); // R8
  AST_UF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cap_uf |=> ctrl_q[CB_RUN]); // R7
endmodule

// File: rtl/dual_reg_timer.sv
module dual_reg_timer
  import dtmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  input  logic          pin_a,
  input  logic          pin_b,
  output logic          pwm_out,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int NB       = W / BW;
  localparam int ADR_CTRL = 0;
  localparam int ADR_CNT  = 1;
  localparam int ADR_A    = ADR_CNT + NB;
  localparam int ADR_B    = ADR_A + NB;
  localparam int ADR_POL  = ADR_B + NB;

  logic [NB-1:0] wr_cnt, wr_a, wr_b;
  logic          wr_ctrl, wr_pol;
  logic [W-1:0]  cnt, ra, rb;
  logic [7:0]    ctrl;
  logic [1:0]    pol;
  logic [2:0]    mode;
  logic          run;
  logic [1:0]    pins, edges;
  tmr_events_t   ev;

  assign wr_ctrl = reg_wr && (reg_addr == AW'(ADR_CTRL));
  assign wr_pol  = reg_wr && (reg_addr == AW'(ADR_POL));

  for (genvar i = 0; i < NB; i++) begin : g_byte_wr
    assign wr_cnt[i] = reg_wr && (reg_addr == AW'(ADR_CNT + i));
    assign wr_a[i]   = reg_wr && (reg_addr == AW'(ADR_A + i));
    assign wr_b[i]   = reg_wr && (reg_addr == AW'(ADR_B + i));
  end

  assign pins = {pin_b, pin_a};
  for (genvar c = 0; c < 2; c++) begin : g_pin
    dtmr_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pins[c]), .fall_sel(pol[c]), .edge_hit(edges[c])
    );
  end

  dtmr_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_pol(wr_pol),
    .wdata(reg_wdata[7:0]), .ev(ev), .ctrl(ctrl), .pol(pol), .mode(mode),
    .run(run), .irq_a(irq_a), .irq_b(irq_b)
  );

  dtmr_count_core #(.W(W), .BW(BW)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .tick(tick),
    .edge_a(edges[0]), .edge_b(edges[1]), .wr_cnt(wr_cnt), .wr_a(wr_a),
    .wr_b(wr_b), .wdata(reg_wdata), .cnt(cnt), .reg_a(ra), .reg_b(rb),
    .pwm(pwm_out), .ev(ev)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADR_CTRL)) reg_rdata[7:0] = ctrl;
    if (reg_addr == AW'(ADR_POL))  reg_rdata[1:0] = pol;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == AW'(ADR_CNT + i)) reg_rdata = cnt[i*BW +: BW];
      if (reg_addr == AW'(ADR_A + i))   reg_rdata = ra[i*BW +: BW];
      if (reg_addr == AW'(ADR_B + i))   reg_rdata = rb[i*BW +: BW];
    end
  end

  AST_IRQ_B_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> (ctrl[1] && ctrl[0])); // R9
endmodule

// File: tb/dual_reg_timer_test.sv
module dual_reg_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pin_a = 1'b0, pin_b = 1'b0;
  logic       pwm_out, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  logic [7:0]  b8;
  logic [15:0] v16, va, vb;
  int n, k, aval, bval, d, len;

  dual_reg_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a(pin_a), .pin_b(pin_b),
    .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_level_len(input int v); return v + 1; endfunction
  function automatic int exp_evt_count(input int start, input int pulses, input int rel);
    if (pulses <= start) return start - pulses;
    return rel - (pulses - start - 1);
  endfunction
  function automatic logic [15:0] exp_gap(input int dd); return 16'(dd); endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] dat);
    reg_addr = a; reg_wdata = dat; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] dat);
    reg_addr = a; #1; dat = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] dat);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); dat = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] dat);
    wr(a, dat[7:0]); wr(a + 3'd1, dat[15:8]);
  endtask

  task automatic clocks(input int c);
    repeat (c) @(posedge clk);
    #1;
  endtask

  task automatic pulse_a();
    pin_a = 1'b1; clocks(3); pin_a = 1'b0; clocks(3);
  endtask

  task automatic wait_pwm(input logic lvl);
    for (int i = 0; i < 200 && pwm_out != lvl; i++) clocks(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    clocks(3);
    rst_n = 1'b1;
    clocks(1);

    // R1 reset state
    rd(3'd0, b8);  chk("R1 ctrl", b8, 0);
    rd16(3'd1, v16); chk("R1 counter", v16, 0);
    rd16(3'd3, v16); chk("R1 reg A", v16, 0);
    rd(3'd7, b8);  chk("R1 edge select", b8, 0);
    chk("R1 outputs", {pwm_out, irq_a, irq_b}, 0);

    // R2 register readback in idle mode
    wr(3'd0, 8'h40);
    wr16(3'd3, 16'hA55A); wr16(3'd5, 16'h3CC3);
    rd16(3'd3, v16); chk("R2 reg A", v16, 16'hA55A);
    rd16(3'd5, v16); chk("R2 reg B", v16, 16'h3CC3);

    // R3 idle code holds counter with ticks running
    wr16(3'd1, 16'h1234);
    clocks(20);
    rd16(3'd1, v16); chk("R3 idle hold", v16, 16'h1234);

    // R4 waveform mode, random reload values
    for (int it = 0; it < 3; it++) begin
      aval = 1 + $urandom % 20; bval = 1 + $urandom % 20;
      wr(3'd0, 8'h40);
      wr16(3'd1, 16'h0000); wr16(3'd3, 16'(aval)); wr16(3'd5, 16'(bval));
      wr(3'd0, 8'h9E);
      wait_pwm(1'b0); wait_pwm(1'b1);
      len = 0;
      for (int i = 0; i < 100 && pwm_out; i++) begin len++; clocks(1); end
      chk("R4 high length", len, exp_level_len(aval));
      len = 0;
      for (int i = 0; i < 100 && !pwm_out; i++) begin len++; clocks(1); end
      chk("R4 low length", len, exp_level_len(bval));
    end
    rd(3'd0, b8); chk("R4 pending A set by reload", b8[3], 1);
    chk("R9 irq_a with enable", irq_a, 1);

    // R8 write 0 clears, write 1 does not set
    wr(3'd0, 8'h00);
    rd(3'd0, b8); chk("R8 clear by 0", b8[3], 0);
    wr(3'd0, 8'h4A);
    rd(3'd0, b8); chk("R8 write 1 no effect", {b8[3], b8[1]}, 0);

    // R6 capture with random edge spacing
    for (int it = 0; it < 4; it++) begin
      d = 1 + $urandom % 30;
      wr(3'd0, 8'h40); wr16(3'd1, 16'h8000);
      wr(3'd0, 8'hC5);
      pin_a = 1'b1; clocks(d); pin_b = 1'b1; clocks(5);
      rd16(3'd3, va); rd16(3'd5, vb);
      chk("R6 capture gap", va - vb, exp_gap(d));
      rd(3'd0, b8); chk("R6 pending A and B", {b8[3], b8[1]}, 2'b11);
      chk("R9 irq lines", {irq_a, irq_b}, 2'b11);
      pin_a = 1'b0; pin_b = 1'b0; clocks(4);
    end

    // R10 falling-edge select on pin A
    wr(3'd0, 8'h40); wr(3'd7, 8'h01); wr16(3'd1, 16'h8000);
    wr(3'd0, 8'hC4);
    pin_a = 1'b1; clocks(5);
    rd(3'd0, b8); chk("R10 rising ignored", b8[3], 0);
    pin_a = 1'b0; clocks(2);
    rd(3'd0, b8); chk("R10 not yet after 2 edges", b8[3], 0);
    clocks(1);
    rd(3'd0, b8); chk("R10 falling captured", b8[3], 1);
    wr(3'd7, 8'h00);

    // R7 capture-mode wrap and flag
    wr(3'd0, 8'h40); wr16(3'd1, 16'h0003);
    wr(3'd0, 8'hC4);
    clocks(6);
    rd16(3'd1, v16); chk("R7 wrap value", v16, 16'hFFFD);
    rd(3'd0, b8); chk("R7 underflow flag", b8[4], 1);
    chk("R9 irq_a from underflow", irq_a, 1);
    wr(3'd0, 8'hC4);
    rd(3'd0, b8); chk("R7 flag cleared", b8[4], 0);
    chk("R9 irq_a dropped", irq_a, 0);

    // R5 event counting with random totals
    for (int it = 0; it < 3; it++) begin
      n = 3 + $urandom % 6; aval = 10 + $urandom % 10; k = 1 + $urandom % (n + 3);
      wr(3'd0, 8'h00); wr16(3'd3, 16'(aval)); wr16(3'd1, 16'(n));
      wr(3'd0, 8'h10);
      for (int p = 0; p < k; p++) pulse_a();
      rd16(3'd1, v16); chk("R5 event count", v16, exp_evt_count(n, k, aval));
      rd(3'd0, b8); chk("R5 pending on reload", b8[3], (k > n) ? 1 : 0);
    end
    wr(3'd0, 8'h00); wr16(3'd1, 16'd9);
    pulse_a(); pulse_a();
    rd16(3'd1, v16); chk("R5 stopped ignores edges", v16, 9);

    finish_run();
  end
endmodule